// File: doc/BRIEF.md
# PCI Configuration Header: Identifier and Status/Command Registers

This block holds the first two dwords of a PCI target's configuration header. Dword 0 carries a fixed vendor code in its low half and a device code in its high half. Dword 1 carries the command controls in its low half and the status word in its high half. Host accesses arrive on a simple register port. That port has a dword offset, four byte enables, write and read strobes, write data, and read data that is registered one cycle after the read strobe.

The device code can come from three sources. A small state machine tracks which source currently owns it. It starts in SRC_DEFAULT, holding the built-in code. It moves from SRC_DEFAULT to SRC_LOADED when the external-memory loader presents a value with `ld_valid`. It moves from SRC_DEFAULT or SRC_LOADED to SRC_HOST when the host writes an enabled byte lane of the device code while the auxiliary enable bit `id_wr_en` is high. SRC_HOST is left only by reset. The loader is accepted once, and only in SRC_DEFAULT. If a host write and a load arrive in the same cycle in SRC_DEFAULT, the host write wins.

The status half combines six event flags with fixed capability bits. Each flag is set by a one-cycle event pulse from the bus interface and is cleared when the host writes a 1 to it. The command half is a set of plain read/write control bits. A parameter mask selects which of these bits exist.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset, a read at offset 0 returns 0x0680_1095 and a read at offset 1 returns 0x0290_0000.
- R2: Bits [15:0] at offset 0 always read 0x1095, and no write changes them.
- R3: The device code (offset 0, bits [31:16]) takes a host write only when `id_wr_en` is 1. Byte enable 2 updates bits [23:16] and byte enable 3 updates bits [31:24]. With `id_wr_en` at 0, such writes leave the code unchanged.
- R4: In SRC_DEFAULT, a cycle with `ld_valid` high replaces the device code with `ld_devid`. Any later load is ignored.
- R5: Once an enabled host write has changed the device code (SRC_HOST), loads are ignored until reset.
- R6: Event inputs set status bits as follows: parity error detected → bit 31, system error signaled → bit 30, master abort received → bit 29, target abort received → bit 28, target abort signaled → bit 27, master data parity error → bit 24.
- R7: A write at offset 1 with byte enable 3 clears each event bit whose write-data bit is 1 and leaves the others unchanged. Without byte enable 3, the event bits are not touched.
- R8: When an event and a clear for the same bit occur in the same cycle, the bit ends set.
- R9: Status bits [26:25] always read 01, bit 23 reads 1, bit 20 reads 1, and bits 22, 21 and [19:16] read 0, regardless of writes.
- R10: Command bits [15:0] reset to 0. A write at offset 1 updates bits [7:0] under byte enable 0 and bits [15:8] under byte enable 1. Only bits set in CMD_MASK (default 0x0557) hold values; all other bits read 0.
- R11: `acc_rdata` is loaded on the clock edge where `acc_rd` is high and holds between reads. Offsets other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_off | input | OFF_W | Dword offset of the access |
| acc_be | input | 4 | Byte enables for writes |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| id_wr_en | input | 1 | Enable bit 0 of the auxiliary configuration register; permits device-code writes |
| ld_valid | input | 1 | Loader presents a device code this cycle |
| ld_devid | input | 16 | Device code from the external-memory loader |
| ev_det_par | input | 1 | Parity error detected as target |
| ev_sig_serr | input | 1 | System error signaled |
| ev_rcv_mabort | input | 1 | Master abort received |
| ev_rcv_tabort | input | 1 | Target abort received |
| ev_sig_tabort | input | 1 | Target abort signaled |
| ev_mst_dpar | input | 1 | Data parity error seen as master |

## Verification
The hardest situation to reach is the interplay between the device-code source states. A load is only honoured in SRC_DEFAULT, and SRC_HOST cannot be left without reset. Each ordering therefore needs its own reset.

The stimulus first loads a value and then repeats the load. Next, it sweeps every byte-enable pattern with the enable bit both low and high. It then loads again in SRC_HOST. Finally, it resets and writes before any load.

For the status flags, every one of the 64 event patterns is also driven in the same cycle as a clear of all bits, to show that set beats clear.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam logic [15:0] VENDOR_CODE  = 16'h1095;
    localparam logic [15:0] DEVICE_DFLT  = 16'h0680;
    localparam int          NUM_EVENTS   = 6;

    typedef enum logic [1:0] {
        SRC_DEFAULT = 2'd0,
        SRC_LOADED  = 2'd1,
        SRC_HOST    = 2'd2
    } id_src_e;

    // Bit position in the dword of event flag i (0 -> 24, 1..5 -> 27..31)
    function automatic int ev_pos(input int i);
        return (i == 0) ? 24 : 26 + i;
    endfunction

endpackage

// File: rtl/cfg_devid_reg.sv
module cfg_devid_reg
    import cfg_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [1:0]  host_be,
    input  logic [15:0] host_data,
    input  logic        host_en,
    input  logic        ld_valid,
    input  logic [15:0] ld_data,
    output logic [15:0] dev_id
);

    id_src_e state_q, state_d;
    logic    host_go;
    logic    ld_take;

    assign host_go = host_wr && host_en && (|host_be);
    assign ld_take = ld_valid && (state_q == SRC_DEFAULT) && !host_go;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_DEFAULT: begin
                if (host_go)       state_d = SRC_HOST;
                else if (ld_valid) state_d = SRC_LOADED;
            end
            SRC_LOADED: begin
                if (host_go)       state_d = SRC_HOST;
            end
            SRC_HOST: begin
                state_d = SRC_HOST;
            end
            default: state_d = SRC_DEFAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_DEFAULT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_id <= DEVICE_DFLT;
        end else if (host_go) begin
            if (host_be[0]) dev_id[7:0]  <= host_data[7:0];
            if (host_be[1]) dev_id[15:8] <= host_data[15:8];
        end else if (ld_take) begin
            dev_id <= ld_data;
        end
    end

    AST_ID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_wr && host_en) && !(ld_valid && state_q == SRC_DEFAULT)) |=> $stable(dev_id)); // R3

    AST_HOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_HOST) |=> (state_q == SRC_HOST)); // R5

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_LOADED && !(host_wr && host_en)) |=> $stable(dev_id)); // R4

endmodule

// File: rtl/cfg_stat_cmd_reg.sv
module cfg_stat_cmd_reg
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] CMD_MASK = 16'h0557
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [3:0]            be,
    input  logic [NUM_EVENTS-1:0] clr_bits,
    input  logic [15:0]           cmd_data,
    input  logic [NUM_EVENTS-1:0] ev,
    output logic [31:0]           value
);

    logic [NUM_EVENTS-1:0] flag_q;
    logic [15:0]           cmd_q;
    logic                  clr_lane;

    assign clr_lane = wr && be[3];

    for (genvar i = 0; i < NUM_EVENTS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                     flag_q[i] <= 1'b0;
            else if (ev[i])                 flag_q[i] <= 1'b1;
            else if (clr_lane && clr_bits[i]) flag_q[i] <= 1'b0;
        end

        AST_EV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flag_q[i]); // R8

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev[i] && clr_lane && clr_bits[i]) |=> !flag_q[i]); // R7

        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev[i] && !(clr_lane && clr_bits[i])) |=> $stable(flag_q[i])); // R7
    end

    for (genvar b = 0; b < 16; b++) begin : g_cmd
        if (CMD_MASK[b]) begin : g_impl
            always_ff @(posedge clk) begin
                if (!rst_n)              cmd_q[b] <= 1'b0;
                else if (wr && be[b/8])  cmd_q[b] <= cmd_data[b];
            end
        end else begin : g_none
            assign cmd_q[b] = 1'b0;
        end
    end

    always_comb begin
        value        = 32'h0290_0000;
        value[15:0]  = cmd_q;
        for (int i = 0; i < NUM_EVENTS; i++) value[ev_pos(i)] = flag_q[i];
    end

    AST_CMD_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && be[0]) |=> $stable(cmd_q[7:0])); // R10

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter int          OFF_W    = 4,
    parameter logic [15:0] CMD_MASK = 16'h0557
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [3:0]       acc_be,
    input  logic             acc_wr,
    input  logic             acc_rd,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  logic             id_wr_en,
    input  logic             ld_valid,
    input  logic [15:0]      ld_devid,
    input  logic             ev_det_par,
    input  logic             ev_sig_serr,
    input  logic             ev_rcv_mabort,
    input  logic             ev_rcv_tabort,
    input  logic             ev_sig_tabort,
    input  logic             ev_mst_dpar
);

    localparam logic [OFF_W-1:0] OFF_IDENT = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_STCMD = OFF_W'(1);

    logic                  hit_ident, hit_stcmd;
    logic [15:0]           dev_id;
    logic [31:0]           stcmd_val;
    logic [NUM_EVENTS-1:0] ev_vec;
    logic [NUM_EVENTS-1:0] clr_vec;
    logic [31:0]           rd_mux;
    logic                  unused_wbits;

    assign hit_ident = (acc_off == OFF_IDENT);
    assign hit_stcmd = (acc_off == OFF_STCMD);

    assign ev_vec  = {ev_det_par, ev_sig_serr, ev_rcv_mabort,
                      ev_rcv_tabort, ev_sig_tabort, ev_mst_dpar};
    assign clr_vec = {acc_wdata[31:27], acc_wdata[24]};
    assign unused_wbits = ^{acc_wdata[26:25], acc_wdata[23:16]};

    cfg_devid_reg u_devid (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (acc_wr && hit_ident),
        .host_be   (acc_be[3:2]),
        .host_data (acc_wdata[31:16]),
        .host_en   (id_wr_en),
        .ld_valid  (ld_valid),
        .ld_data   (ld_devid),
        .dev_id    (dev_id)
    );

    cfg_stat_cmd_reg #(.CMD_MASK(CMD_MASK)) u_stcmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (acc_wr && hit_stcmd),
        .be       (acc_be),
        .clr_bits (clr_vec),
        .cmd_data (acc_wdata[15:0]),
        .ev       (ev_vec),
        .value    (stcmd_val)
    );

    always_comb begin
        if (hit_ident)      rd_mux = {dev_id, VENDOR_CODE};
        else if (hit_stcmd) rd_mux = stcmd_val;
        else                rd_mux = 32'h0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      acc_rdata <= 32'h0;
        else if (acc_rd) acc_rdata <= rd_mux;
    end

    AST_VENDOR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && hit_ident) |=> (acc_rdata[15:0] == 16'h1095)); // R2

    AST_HARDWIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && hit_stcmd) |=> (acc_rdata[26:25] == 2'b01 && acc_rdata[23]
                                   && !acc_rdata[22] && acc_rdata[20])); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(acc_rdata)); // R11

endmodule

// File: tb/test_cfg_hdr_regs.sv
module test_cfg_hdr_regs;

    localparam logic [15:0] MASK = 16'h0557;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  acc_off = '0;
    logic [3:0]  acc_be = '0;
    logic        acc_wr = 1'b0, acc_rd = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        id_wr_en = 1'b0, ld_valid = 1'b0;
    logic [15:0] ld_devid = '0;
    logic [5:0]  ev = '0;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_dev;
    logic [5:0]  m_stat;
    logic [15:0] m_cmd;
    logic [31:0] rd;

    always #10 clk = ~clk;

    cfg_hdr_regs #(.OFF_W(4), .CMD_MASK(MASK)) i_cfg_hdr_regs (
        .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .acc_be(acc_be),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .id_wr_en(id_wr_en), .ld_valid(ld_valid), .ld_devid(ld_devid),
        .ev_det_par(ev[5]), .ev_sig_serr(ev[4]), .ev_rcv_mabort(ev[3]),
        .ev_rcv_tabort(ev[2]), .ev_sig_tabort(ev[1]), .ev_mst_dpar(ev[0])
    );

    function automatic logic [31:0] map_ev(input logic [5:0] p);
        return {p[5:1], 2'b00, p[0], 24'h0};
    endfunction

    function automatic logic [31:0] exp_sc();
        return 32'h0290_0000 | map_ev(m_stat) | {16'h0, m_cmd};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_dev = 16'h0680; m_stat = '0; m_cmd = '0;
    endtask

    task automatic do_write(input logic [3:0] off, input logic [3:0] be, input logic [31:0] d,
                            input logic [5:0] evp);
        @(negedge clk);
        acc_off = off; acc_be = be; acc_wdata = d; acc_wr = 1'b1; ev = evp;
        @(negedge clk);
        acc_wr = 1'b0; ev = '0;
    endtask

    task automatic do_read(input logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        acc_off = off; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        d = acc_rdata;
    endtask

    task automatic do_load(input logic [15:0] v);
        @(negedge clk); ld_valid = 1'b1; ld_devid = v;
        @(negedge clk); ld_valid = 1'b0;
    endtask

    task automatic pulse_ev(input logic [5:0] p);
        @(negedge clk); ev = p;
        @(negedge clk); ev = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset values
        do_read(4'd0, rd); check("R1 ident", rd, 32'h0680_1095);
        do_read(4'd1, rd); check("R1 stcmd", rd, 32'h0290_0000);

        // R4 load in default state, then a second load ignored
        do_load(16'hBEEF); m_dev = 16'hBEEF;
        do_read(4'd0, rd); check("R4 load", rd, {m_dev, 16'h1095});
        do_load(16'h1234);
        do_read(4'd0, rd); check("R4 reload ignored", rd, {m_dev, 16'h1095});

        // R2 R3 sweep of enable and byte enables
        for (int en = 0; en < 2; en++) begin
            for (int be = 0; be < 16; be++) begin
                logic [15:0] hi;
                hi = 16'hC3A0 ^ (16'(be) * 16'h0111) ^ (en != 0 ? 16'h0F0F : 16'h0);
                id_wr_en = en[0];
                do_write(4'd0, be[3:0], {hi, 16'hFFFF}, 6'h0);
                if (en != 0) begin
                    if (be[2]) m_dev[7:0]  = hi[7:0];
                    if (be[3]) m_dev[15:8] = hi[15:8];
                end
                do_read(4'd0, rd); check("R2 R3 id write", rd, {m_dev, 16'h1095});
            end
        end
        id_wr_en = 1'b0;

        // R5 load after host write ignored
        do_load(16'h5A5A);
        do_read(4'd0, rd); check("R5 load after host", rd, {m_dev, 16'h1095});
        do_reset();
        id_wr_en = 1'b1;
        do_write(4'd0, 4'b0100, 32'h0077_0000, 6'h0); m_dev[7:0] = 8'h77;
        id_wr_en = 1'b0;
        do_load(16'h4321);
        do_read(4'd0, rd); check("R5 host first", rd, {m_dev, 16'h1095});

        // R6 R7 R8 status sweep
        for (int p = 0; p < 64; p++) begin
            logic [5:0] c;
            c = 6'(p) ^ 6'h2A;
            do_write(4'd1, 4'b1000, 32'hFF00_0000, 6'h0); m_stat = '0;
            pulse_ev(6'(p)); m_stat = 6'(p);
            do_read(4'd1, rd); check("R6 event set", rd, exp_sc());
            do_write(4'd1, 4'b0111, map_ev(c), 6'h0);
            do_read(4'd1, rd); check("R7 no lane", rd, exp_sc());
            do_write(4'd1, 4'b1000, map_ev(c), 6'h0); m_stat = m_stat & ~c;
            do_read(4'd1, rd); check("R7 w1c", rd, exp_sc());
            do_write(4'd1, 4'b1000, 32'hFF00_0000, 6'(p)); m_stat = 6'(p);
            do_read(4'd1, rd); check("R8 set wins", rd, exp_sc());
        end

        // R10 command sweep
        for (int be = 0; be < 16; be++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] d;
                d = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : (k == 2) ? 16'hA5C3 : 16'(be) * 16'h1357;
                do_write(4'd1, be[3:0], {8'h00, 8'hFF, d}, 6'h0);
                if (be[0]) m_cmd[7:0]  = d[7:0] & MASK[7:0];
                if (be[1]) m_cmd[15:8] = d[15:8] & MASK[15:8];
                do_read(4'd1, rd); check("R10 cmd", rd, exp_sc());
            end
        end

        // R9 hardwired fields under full writes
        pulse_ev(6'h3F); m_stat = 6'h3F;
        do_write(4'd1, 4'hF, 32'hFFFF_FFFF, 6'h0); m_stat = '0; m_cmd = MASK;
        do_read(4'd1, rd); check("R9 all ones", rd, 32'h0290_0000 | {16'h0, MASK});
        do_write(4'd1, 4'hF, 32'h0000_0000, 6'h0); m_cmd = '0;
        do_read(4'd1, rd); check("R9 all zeros", rd, 32'h0290_0000);

        // R11 other offsets and hold between reads
        do_read(4'd3, rd); check("R11 unmapped", rd, 32'h0);
        do_read(4'd0, rd);
        do_write(4'd1, 4'h1, 32'h0000_00FF, 6'h0);
        repeat (2) @(negedge clk);
        check("R11 hold", acc_rdata, {m_dev, 16'h1095});

        finish_run();
    end

endmodule